// File: doc/BRIEF.md
# Conditional Branch and Call Sequencer

This block is the control-flow engine of a small 8-bit processor core with a 16-bit address space. The core's decoder hands it one operation (absolute jump, relative jump, subroutine call, return, return-from-interrupt or jump through HL) together with a condition code, the current zero and carry flags, and the current PC, SP and HL values. The sequencer then runs the bus cycles the operation needs on a byte-wide memory port. It fetches the immediate operand bytes, pushes or pops the return address on a stack that grows toward lower addresses, and inserts one internal idle cycle whenever a branch is taken. It finishes by presenting the new PC and SP.

The memory port uses a zero-wait model. In a cycle with `rd_en` high, the data on `rdata` is captured at the clock edge that ends that cycle. In a cycle with `wr_en` high, `addr` and `wdata` describe a single byte store. The input `pc_in` is the address of the opcode byte, so the operand bytes sit at `pc_in+1` and `pc_in+2`. A `busy`/`done` pair tells the core when the results are ready.

Top module: `flow_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en`, `wr_en` and `int_en` are low and `pc_out` and `sp_out` are zero.
- R2: `op` encodes 0 = absolute jump, 1 = relative jump, 2 = call, 3 = return, 4 = return-from-interrupt, 5 = jump to HL; codes 6 and 7 are reserved. `cc` encodes 0 = always, 1 = carry set, 2 = zero set, 3 = carry clear, 4 = zero clear; codes 5 to 7 never pass.
- R3: An absolute jump reads `pc_in+1` (low byte) and then `pc_in+2` (high byte). When its condition passes, it spends one extra idle cycle (3 busy cycles) and `pc_out` is high:low. Otherwise it takes 2 busy cycles and `pc_out = pc_in+3`.
- R4: A relative jump reads one byte at `pc_in+1`. When its condition passes, `pc_out = pc_in+2+` the sign-extended byte, after 2 busy cycles. Otherwise it takes 1 busy cycle and `pc_out = pc_in+2`.
- R5: A call whose condition passes does the following over 5 busy cycles: it writes the low byte of `pc_in+3` at `sp_in-2`, writes the high byte at `sp_in-1`, reads `pc_in+1` and then `pc_in+2`, and idles one cycle. It ends with `pc_out` = high:low and `sp_out = sp_in-2`.
- R6: A call whose condition fails reads `pc_in+1` and `pc_in+2` with no writes, over 2 busy cycles. It ends with `pc_out = pc_in+3` and `sp_out = sp_in`.
- R7: A return whose condition passes reads `sp_in` (low byte) and then `sp_in+1` (high byte), and idles one cycle (3 busy cycles). It ends with `pc_out` = high:low and `sp_out = sp_in+2`.
- R8: A return whose condition fails makes no bus access during its single busy cycle. It ends with `pc_out = pc_in+1` and `sp_out = sp_in`.
- R9: Return-from-interrupt ignores `cc` and the flags and always behaves as a taken return. `int_en` is high exactly in the cycle its `done` is high and is low on every other `done`.
- R10: Jump to HL ignores `cc` and the flags. It makes no bus access during its single busy cycle and ends with `pc_out = hl_in` and `sp_out = sp_in`.
- R11: `start` is accepted only while `busy` is low. `busy` rises in the cycle after acceptance and stays high through the last work cycle. `done` is a one-cycle pulse in the cycle that follows. `pc_out` and `sp_out` change only together with `done` and hold until the next `done`. `start` and the operation inputs are ignored while `busy` is high.
- R12: `rd_en` and `wr_en` are never high together, and neither is high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to run the presented operation |
| op | input | 3 | Operation code |
| cc | input | 3 | Condition code |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc_in | input | 16 | Address of the opcode byte |
| sp_in | input | 16 | Current stack pointer |
| hl_in | input | 16 | Current HL register pair |
| rdata | input | 8 | Memory read data |
| addr | output | 16 | Memory address |
| wdata | output | 8 | Memory write data |
| rd_en | output | 1 | Read strobe |
| wr_en | output | 1 | Write strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting PC |
| sp_out | output | 16 | Resulting SP |
| int_en | output | 1 | Interrupt re-enable pulse |

## Verification
The bench sweeps every operation against every condition code and flag pairing, over three address layouts. It compares the full per-cycle bus trace, so a wrong cycle count or a skipped stall shows up as a trace mismatch. The layouts place the return address, the push and the pop across the 0xFFFF/0x0000 wrap. A design that carried the byte arithmetic in 8 bits would then write to the wrong page or return to the wrong place. Relative offsets of 0x80 and 0x7F catch a design that zero-extends the offset and lands 256 bytes off. A start request held high with a different operation code during a sequence catches a design that re-samples its inputs mid-flight. Reserved condition codes catch a design that defaults them to "always", which would make failed calls push to the stack.

// File: rtl/flow_pkg.sv
package flow_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    OP_JABS = 3'd0,
    OP_JREL = 3'd1,
    OP_CALL = 3'd2,
    OP_RET  = 3'd3,
    OP_RETI = 3'd4,
    OP_JHL  = 3'd5
  } flow_op_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_CSET   = 3'd1,
    CC_ZSET   = 3'd2,
    CC_CCLR   = 3'd3,
    CC_ZCLR   = 3'd4
  } flow_cc_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPLO,
    ST_OPHI,
    ST_PUSHLO,
    ST_PUSHHI,
    ST_POPLO,
    ST_POPHI,
    ST_STALL,
    ST_SKIP
  } flow_st_e;

  // Condition evaluation; reserved codes never pass.
  function automatic logic cond_met(logic [2:0] cc, logic z, logic c);
    case (cc)
      CC_ALWAYS: return 1'b1;
      CC_CSET:   return c;
      CC_ZSET:   return z;
      CC_CCLR:   return !c;
      CC_ZCLR:   return !z;
      default:   return 1'b0;
    endcase
  endfunction

  // Address of the instruction following the current one.
  function automatic word_t fall_through(flow_op_e op, word_t pc);
    case (op)
      OP_JABS, OP_CALL: return pc + word_t'(3);
      OP_JREL:          return pc + word_t'(2);
      default:          return pc + word_t'(1);
    endcase
  endfunction

  // Relative target: offset is measured from the byte after the operand.
  function automatic word_t rel_target(word_t pc, byte_t off);
    return pc + word_t'(2) + {{BYTE_W{off[BYTE_W-1]}}, off};
  endfunction

  function automatic word_t join_bytes(byte_t hi, byte_t lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/flow_cond.sv
module flow_cond
  import flow_pkg::*;
(
  input  flow_op_e   op,
  input  logic [2:0] cc,
  input  logic       flag_z,
  input  logic       flag_c,
  output logic       taken
);

  // Return-from-interrupt and jump-through-HL are unconditional.
  always_comb begin
    if (op == OP_RETI || op == OP_JHL) taken = 1'b1;
    else                               taken = cond_met(cc, flag_z, flag_c);
  end

endmodule

// File: rtl/flow_fsm.sv
module flow_fsm
  import flow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  flow_op_e op,
  input  logic     taken,
  output flow_st_e state,
  output flow_op_e op_q,
  output logic     taken_q,
  output logic     accept,
  output logic     finish,
  output logic     busy
);

  flow_st_e state_q, state_d;

  assign accept = start && (state_q == ST_IDLE);
  assign busy   = (state_q != ST_IDLE);
  assign state  = state_q;

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          case (op)
            OP_JABS, OP_JREL: state_d = ST_OPLO;
            OP_CALL:          state_d = taken ? ST_PUSHLO : ST_OPLO;
            OP_RET, OP_RETI:  state_d = taken ? ST_POPLO : ST_SKIP;
            default:          state_d = ST_SKIP;
          endcase
        end
      end
      ST_OPLO: begin
        if (op_q == OP_JREL) begin
          if (taken_q) state_d = ST_STALL;
          else begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end
        end else begin
          state_d = ST_OPHI;
        end
      end
      ST_OPHI: begin
        if (taken_q) state_d = ST_STALL;
        else begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end
      end
      ST_PUSHLO: state_d = ST_PUSHHI;
      ST_PUSHHI: state_d = ST_OPLO;
      ST_POPLO:  state_d = ST_POPHI;
      ST_POPHI:  state_d = ST_STALL;
      ST_STALL, ST_SKIP: begin
        state_d = ST_IDLE;
        finish  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_JABS;
      taken_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q    <= op;
        taken_q <= taken;
      end
    end
  end

endmodule

// File: rtl/flow_dp.sv
module flow_dp
  import flow_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  logic     finish,
  input  flow_st_e state,
  input  flow_op_e op_q,
  input  logic     taken_q,
  input  word_t    pc_in,
  input  word_t    sp_in,
  input  word_t    hl_in,
  input  byte_t    rdata,
  output word_t    addr,
  output byte_t    wdata,
  output logic     rd_en,
  output logic     wr_en,
  output word_t    pc_out,
  output word_t    sp_out,
  output logic     done,
  output logic     int_en
);

  word_t pc_q, sp_q, hl_q;
  byte_t lo_q, hi_q;
  word_t ret_addr, pc_res, sp_res;

  assign ret_addr = fall_through(OP_CALL, pc_q);

  // Bus drive per state.
  always_comb begin
    addr  = '0;
    wdata = '0;
    rd_en = 1'b0;
    wr_en = 1'b0;
    case (state)
      ST_OPLO:   begin rd_en = 1'b1; addr = pc_q + word_t'(1); end
      ST_OPHI:   begin rd_en = 1'b1; addr = pc_q + word_t'(2); end
      ST_PUSHLO: begin wr_en = 1'b1; addr = sp_q - word_t'(2); wdata = ret_addr[BYTE_W-1:0]; end
      ST_PUSHHI: begin wr_en = 1'b1; addr = sp_q - word_t'(1); wdata = ret_addr[WORD_W-1:BYTE_W]; end
      ST_POPLO:  begin rd_en = 1'b1; addr = sp_q; end
      ST_POPHI:  begin rd_en = 1'b1; addr = sp_q + word_t'(1); end
      default: ;
    endcase
  end

  // Result selection.
  always_comb begin
    pc_res = fall_through(op_q, pc_q);
    sp_res = sp_q;
    if (taken_q) begin
      case (op_q)
        OP_JABS: pc_res = join_bytes(hi_q, lo_q);
        OP_JREL: pc_res = rel_target(pc_q, lo_q);
        OP_CALL: begin
          pc_res = join_bytes(hi_q, lo_q);
          sp_res = sp_q - word_t'(2);
        end
        OP_RET, OP_RETI: begin
          pc_res = join_bytes(hi_q, lo_q);
          sp_res = sp_q + word_t'(2);
        end
        OP_JHL:  pc_res = hl_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      sp_q   <= '0;
      hl_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      pc_out <= '0;
      sp_out <= '0;
      done   <= 1'b0;
      int_en <= 1'b0;
    end else begin
      if (accept) begin
        pc_q <= pc_in;
        sp_q <= sp_in;
        hl_q <= hl_in;
      end
      if (state == ST_OPLO || state == ST_POPLO) lo_q <= rdata;
      if (state == ST_OPHI || state == ST_POPHI) hi_q <= rdata;
      done   <= finish;
      int_en <= finish && (op_q == OP_RETI);
      if (finish) begin
        pc_out <= pc_res;
        sp_out <= sp_res;
      end
    end
  end

endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [2:0]  cc,
  input  logic        flag_z,
  input  logic        flag_c,
  input  logic [15:0] pc_in,
  input  logic [15:0] sp_in,
  input  logic [15:0] hl_in,
  input  logic [7:0]  rdata,
  output logic [15:0] addr,
  output logic [7:0]  wdata,
  output logic        rd_en,
  output logic        wr_en,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic [15:0] sp_out,
  output logic        int_en
);

  flow_op_e op_in;
  flow_op_e op_q;
  flow_st_e state;
  logic     ev_taken;
  logic     ev_accept;
  logic     ev_finish;
  logic     taken_q;

  assign op_in = flow_op_e'(op);

  flow_cond u_cond (
    .op     (op_in),
    .cc     (cc),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .taken  (ev_taken)
  );

  flow_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op_in),
    .taken   (ev_taken),
    .state   (state),
    .op_q    (op_q),
    .taken_q (taken_q),
    .accept  (ev_accept),
    .finish  (ev_finish),
    .busy    (busy)
  );

  flow_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (ev_accept),
    .finish  (ev_finish),
    .state   (state),
    .op_q    (op_q),
    .taken_q (taken_q),
    .pc_in   (pc_in),
    .sp_in   (sp_in),
    .hl_in   (hl_in),
    .rdata   (rdata),
    .addr    (addr),
    .wdata   (wdata),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .pc_out  (pc_out),
    .sp_out  (sp_out),
    .done    (done),
    .int_en  (int_en)
  );

endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        rd_en,
  input logic        wr_en,
  input logic [15:0] addr,
  input logic        int_en,
  input logic [15:0] pc_out,
  input logic [15:0] sp_out,
  input logic        ev_accept,
  input logic        ev_finish
);

  a_r12_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rd_en || wr_en));

  a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);

  a_r11_finish_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> (done && !busy));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pc_out) && $stable(sp_out)));

  a_r9_int_en_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    int_en |-> done);

  a_r5_push_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (addr == $past(addr) + 16'd1));

  a_r5_push_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !wr_en) |-> rd_en);

endmodule

bind flow_seq flow_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .addr      (addr),
  .int_en    (int_en),
  .pc_out    (pc_out),
  .sp_out    (sp_out),
  .ev_accept (ev_accept),
  .ev_finish (ev_finish)
);

// File: tb/sim_flow_seq.sv
module sim_flow_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [2:0]  cc = 3'd0;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic [15:0] pc_in = 16'h0;
  logic [15:0] sp_in = 16'h0;
  logic [15:0] hl_in = 16'h0;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rd_en, wr_en, busy, done, int_en;
  logic [15:0] pc_out, sp_out;

  // Memory image for the current run.
  logic [7:0] b1, b2, s0, s1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;

  always #10 clk = ~clk;

  flow_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cc(cc),
    .flag_z(flag_z), .flag_c(flag_c), .pc_in(pc_in), .sp_in(sp_in),
    .hl_in(hl_in), .rdata(rdata), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .busy(busy), .done(done),
    .pc_out(pc_out), .sp_out(sp_out), .int_en(int_en)
  );

  always_comb begin
    if      (addr == pc_in + 16'd1) rdata = b1;
    else if (addr == pc_in + 16'd2) rdata = b2;
    else if (addr == sp_in)         rdata = s0;
    else if (addr == sp_in + 16'd1) rdata = s1;
    else                            rdata = 8'h00;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (op %0d cc %0d z %0b c %0b pc %04h sp %04h)",
               tag, what, act, exp, op, cc, flag_z, flag_c, pc_in, sp_in);
    end
  endtask

  function automatic bit cond_ref(input logic [2:0] c_code, input logic z, input logic c);
    if (c_code == 3'd0) return 1'b1;
    if (c_code == 3'd1) return c;
    if (c_code == 3'd2) return z;
    if (c_code == 3'd3) return !c;
    if (c_code == 3'd4) return !z;
    return 1'b0;
  endfunction

  task automatic run_seq(input logic [2:0] o, input logic [2:0] c_code, input logic z,
                         input logic c, input bit hold);
    logic [1:0]  ek [8];
    logic [15:0] ea [8];
    logic [7:0]  ed [8];
    int n = 0;
    int seen = 0;
    bit tk;
    logic [15:0] epc, esp, ret;
    string tag;
    tk  = (o == 3'd4 || o == 3'd5) ? 1'b1 : cond_ref(c_code, z, c);
    epc = pc_in + 16'd1;
    esp = sp_in;
    ret = pc_in + 16'd3;
    for (int i = 0; i < 8; i++) begin ek[i] = 2'd0; ea[i] = 16'h0; ed[i] = 8'h0; end
    case (o)
      3'd0: begin // R3
        tag = "R3";
        ek[0] = 2'd1; ea[0] = pc_in + 16'd1;
        ek[1] = 2'd1; ea[1] = pc_in + 16'd2;
        n = tk ? 3 : 2;
        epc = tk ? {b2, b1} : pc_in + 16'd3;
      end
      3'd1: begin // R4
        tag = "R4";
        ek[0] = 2'd1; ea[0] = pc_in + 16'd1;
        n = tk ? 2 : 1;
        epc = tk ? (pc_in + 16'd2 + {{8{b1[7]}}, b1}) : pc_in + 16'd2;
      end
      3'd2: begin // R5 / R6
        tag = tk ? "R5" : "R6";
        if (tk) begin
          ek[0] = 2'd2; ea[0] = sp_in - 16'd2; ed[0] = ret[7:0];
          ek[1] = 2'd2; ea[1] = sp_in - 16'd1; ed[1] = ret[15:8];
          ek[2] = 2'd1; ea[2] = pc_in + 16'd1;
          ek[3] = 2'd1; ea[3] = pc_in + 16'd2;
          n = 5;
          epc = {b2, b1};
          esp = sp_in - 16'd2;
        end else begin
          ek[0] = 2'd1; ea[0] = pc_in + 16'd1;
          ek[1] = 2'd1; ea[1] = pc_in + 16'd2;
          n = 2;
          epc = pc_in + 16'd3;
        end
      end
      3'd3, 3'd4: begin // R7 / R8 / R9
        tag = (o == 3'd4) ? "R9" : (tk ? "R7" : "R8");
        if (tk) begin
          ek[0] = 2'd1; ea[0] = sp_in;
          ek[1] = 2'd1; ea[1] = sp_in + 16'd1;
          n = 3;
          epc = {s1, s0};
          esp = sp_in + 16'd2;
        end else begin
          n = 1;
        end
      end
      default: begin // R10
        tag = "R10";
        n = 1;
        epc = hl_in;
      end
    endcase
    if (hold) tag = "R11";

    @(negedge clk);
    op = o; cc = c_code; flag_z = z; flag_c = c; start = 1'b1;
    @(negedge clk);
    if (hold) begin op = 3'd5; cc = 3'd7; end
    else start = 1'b0;
    while (!done && seen < 12) begin
      if (busy) begin
        if (seen < 8) begin
          chk(tag, "bus kind", {30'd0, (rd_en ? 2'd1 : (wr_en ? 2'd2 : 2'd0))}, {30'd0, ek[seen]});
          if (rd_en || wr_en) chk(tag, "bus addr", {16'd0, addr}, {16'd0, ea[seen]});
          if (wr_en) chk(tag, "write data", {24'd0, wdata}, {24'd0, ed[seen]});
        end
        seen++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(tag, "busy cycles", seen, n);
    chk(tag, "done seen", {31'd0, done}, 32'd1);
    chk(tag, "pc_out", {16'd0, pc_out}, {16'd0, epc});
    chk(tag, "sp_out", {16'd0, sp_out}, {16'd0, esp});
    chk("R9", "int_en at done", {31'd0, int_en}, {31'd0, (o == 3'd4)});
    @(negedge clk);
    chk("R11", "done single pulse", {31'd0, done}, 32'd0);
    chk("R11", "pc_out held", {16'd0, pc_out}, {16'd0, epc});
    chk("R11", "no re-accept", {31'd0, busy}, 32'd0);
  endtask

  task automatic set_layout(input int p);
    case (p)
      0: begin pc_in = 16'h1200; sp_in = 16'hD000; hl_in = 16'h4321;
               b1 = 8'h34; b2 = 8'h56; s0 = 8'h78; s1 = 8'h9A; end
      1: begin pc_in = 16'hFFFC; sp_in = 16'h0001; hl_in = 16'hFFFF;
               b1 = 8'h80; b2 = 8'hC3; s0 = 8'h11; s1 = 8'hEE; end
      default: begin pc_in = 16'h00F0; sp_in = 16'hFFFF; hl_in = 16'h0000;
               b1 = 8'h7F; b2 = 8'h01; s0 = 8'hA5; s1 = 8'h5A; end
    endcase
  endtask

  initial begin
    set_layout(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", {31'd0, busy}, 32'd0);
    chk("R1", "done", {31'd0, done}, 32'd0);
    chk("R1", "strobes", {30'd0, rd_en, wr_en}, 32'd0);
    chk("R1", "int_en", {31'd0, int_en}, 32'd0);
    chk("R1", "pc_out", {16'd0, pc_out}, 32'd0);
    chk("R1", "sp_out", {16'd0, sp_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", {31'd0, busy}, 32'd0);

    // R2: full sweep of op, cc and flags over three layouts (R12 via checker)
    for (int p = 0; p < 3; p++) begin
      set_layout(p);
      for (int o = 0; o < 6; o++)
        for (int k = 0; k < 8; k++)
          for (int f = 0; f < 4; f++)
            run_seq(3'(o), 3'(k), f[1], f[0], 1'b0);
    end

    // R11: start held high with other inputs while busy
    set_layout(0);
    run_seq(3'd0, 3'd0, 1'b0, 1'b0, 1'b1);
    set_layout(1);
    run_seq(3'd2, 3'd1, 1'b0, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule